// File: doc/BRIEF.md
# DMA Stream Staging FIFO with Width Packing

This block sits inside one DMA stream, between the side that reads from the source and the side that writes to the destination. When enabled, it holds up to four 32-bit words of data. Source units of one width (byte, halfword or word) are packed into that storage and handed out as destination units of another width. The write side is only told that data is ready once the fill level reaches a programmed threshold. At the end of a transfer, a flush pulse releases whatever is left, even when it is below the threshold or shorter than a destination unit. When disabled, the block is a plain wire from the source strobe to the destination strobe.

Both sides are strobe driven. The read side pulses `push_en` with a unit on `push_data`. The write side watches `pop_avail` and pulses `pop_req` to take the unit shown on `pop_data`. The read side does not wait for the write side to ask for data, so the storage fills ahead of demand (prefill). A push that does not fit and a pop with nothing available both set a sticky error flag. A threshold setting that the destination burst length cannot divide sets a separate configuration flag.

Top module: `dma_pack_fifo`

## Requirements
- R1: After synchronous reset, `pop_avail`, `fifo_err` and `cfg_err` are 0 and the store is empty.
- R2: Bytes are stored little-endian. The lowest byte of a pushed unit is stored first, and the first stored byte appears in `pop_data[7:0]` of the next popped unit, with later bytes in rising byte lanes.
- R3: When enabled and not flushing, `pop_avail` is 1 only when the number of stored bytes is at least the threshold and at least one destination unit. The threshold in bytes is (thr_sel+1)*4: code 0 is one quarter, 1 is half, 2 is three quarters and 3 is full (16 bytes).
- R4: Unit sizes use the code 0 = byte, 1 = halfword, 2 = word. A pop removes one destination unit, which may differ from the source unit, and the lanes of `pop_data` above that unit read 0.
- R5: A `flush` pulse while enabled makes the block drain regardless of threshold. A final unit shorter than a destination unit is popped with its missing upper bytes reading 0. Flush mode ends in the cycle the store becomes empty.
- R6: A push whose unit does not fit in the free space is dropped, the stored data is kept, and `fifo_err` is 1 from the next cycle on.
- R7: A `pop_req` while `pop_avail` is 0 removes nothing, and `fifo_err` is 1 from the next cycle on. `fifo_err` stays set until reset.
- R8: With `fifo_en` at 0, `pop_avail` equals `push_en` and `pop_data` equals `push_data` in the same cycle. Nothing is stored and neither error flag is set.
- R9: `cfg_err` is 1 one cycle after an enabled configuration in which the threshold in bytes is not a whole multiple of the destination burst. The burst in bytes is the beat count (code 0 = 1, 1 = 4, 2 = 8, 3 = 16 beats) times the destination unit size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = staging store in use, 0 = pass-through |
| thr_sel | input | 2 | Drain threshold code |
| src_size | input | 2 | Source unit size code |
| dst_size | input | 2 | Destination unit size code |
| dst_burst | input | 2 | Destination burst length code |
| push_en | input | 1 | Source unit strobe |
| push_data | input | 32 | Source unit, right-aligned |
| pop_req | input | 1 | Destination take strobe |
| pop_avail | output | 1 | A destination unit may be taken |
| pop_data | output | 32 | Destination unit, right-aligned |
| flush | input | 1 | End-of-transfer drain pulse |
| fifo_err | output | 1 | Sticky overflow or underflow flag |
| cfg_err | output | 1 | Threshold and burst mismatch flag |

## Verification
The assertions assume that the size, threshold and enable inputs do not change while data is held. If they did, the level bound and the drain gate would be judged against a configuration other than the one the data was stored under. The bench keeps to this by changing configuration only while reset is held or while the store is empty. Each cycle it compares the outputs with a byte-queue model, covering random mixes of pushes, pops and flushes as well as the directed overflow, underflow, bypass and configuration cases.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } unit_sz_e;

  // bytes carried by one unit of the given size code
  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: unit_bytes = 3'd1;
      SZ_HALF: unit_bytes = 3'd2;
      default: unit_bytes = 3'd4;
    endcase
  endfunction

  // beats in one destination burst
  function automatic logic [4:0] burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    burst_beats = 5'd1;
      2'd1:    burst_beats = 5'd4;
      2'd2:    burst_beats = 5'd8;
      default: burst_beats = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dpf_byte_store.sv
module dpf_byte_store #(
  parameter int CAP = 16,
  parameter int BPW = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_go,
  input  logic [$clog2(BPW+1)-1:0]   wr_n,
  input  logic [8*BPW-1:0]           wr_data,
  input  logic                       rd_go,
  input  logic [$clog2(BPW+1)-1:0]   rd_n,
  output logic [8*BPW-1:0]           rd_window
);
  localparam int PW = $clog2(CAP);
  localparam int NW = $clog2(BPW+1);

  logic [7:0]    mem [CAP];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  // byte-lane writes, no reset on the array
  always_ff @(posedge clk) begin
    for (int k = 0; k < BPW; k++) begin
      if (wr_go && (NW'(k) < wr_n))
        mem[wr_ptr + PW'(k)] <= wr_data[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_go) wr_ptr <= wr_ptr + PW'(wr_n);
      if (rd_go) rd_ptr <= rd_ptr + PW'(rd_n);
    end
  end

  always_comb begin
    for (int k = 0; k < BPW; k++)
      rd_window[8*k +: 8] = mem[rd_ptr + PW'(k)];
  end

endmodule

// File: rtl/dpf_drain_ctl.sv
module dpf_drain_ctl #(
  parameter int CAP = 16,
  parameter int BPW = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fifo_en,
  input  logic                       push_en,
  input  logic [$clog2(BPW+1)-1:0]   src_n,
  input  logic                       pop_req,
  input  logic [$clog2(BPW+1)-1:0]   dst_n,
  input  logic [$clog2(CAP+1)-1:0]   thr_n,
  input  logic                       flush,
  output logic                       wr_go,
  output logic                       rd_go,
  output logic [$clog2(BPW+1)-1:0]   rd_n,
  output logic [$clog2(CAP+1)-1:0]   level,
  output logic                       flush_active,
  output logic                       avail,
  output logic                       fifo_err
);
  localparam int CW = $clog2(CAP+1);
  localparam int NW = $clog2(BPW+1);

  logic          room_ok;
  logic [CW-1:0] level_n;
  logic          short_tail;

  assign room_ok    = ({1'b0, level} + (CW+1)'(src_n)) <= (CW+1)'(CAP);
  assign short_tail = level < CW'(dst_n);

  always_comb begin
    avail = 1'b0;
    if (fifo_en && (level != '0)) begin
      if (flush_active) avail = 1'b1;
      else              avail = !short_tail && (level >= thr_n);
    end
  end

  assign rd_n  = short_tail ? NW'(level) : dst_n;
  assign wr_go = fifo_en && push_en && room_ok;
  assign rd_go = fifo_en && pop_req && avail;

  always_comb begin
    level_n = level;
    if (wr_go) level_n = level_n + CW'(src_n);
    if (rd_go) level_n = level_n - CW'(rd_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level        <= '0;
      flush_active <= 1'b0;
      fifo_err     <= 1'b0;
    end else begin
      level <= level_n;
      if (fifo_en && flush)
        flush_active <= 1'b1;
      else if (flush_active && (level_n == '0))
        flush_active <= 1'b0;
      if (fifo_en && ((push_en && !room_ok) || (pop_req && !avail)))
        fifo_err <= 1'b1;
    end
  end

endmodule

// File: rtl/dpf_cfg_check.sv
module dpf_cfg_check #(
  parameter int CAP = 16,
  parameter int BPW = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fifo_en,
  input  logic [$clog2(CAP+1)-1:0]   thr_n,
  input  logic [$clog2(BPW+1)-1:0]   dst_n,
  input  logic [1:0]                 dst_burst,
  output logic                       cfg_err
);
  import dpf_pkg::*;

  localparam int MW = 8;

  logic [MW-1:0] burst_n;
  logic          misfit;

  assign burst_n = MW'(burst_beats(dst_burst)) * MW'(dst_n);
  assign misfit  = (MW'(thr_n) % burst_n) != '0;

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= fifo_en && misfit;
  end

endmodule

// File: rtl/dma_pack_fifo.sv
module dma_pack_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic [1:0]        thr_sel,
  input  logic [1:0]        src_size,
  input  logic [1:0]        dst_size,
  input  logic [1:0]        dst_burst,
  input  logic              push_en,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop_req,
  output logic              pop_avail,
  output logic [WORD_W-1:0] pop_data,
  input  logic              flush,
  output logic              fifo_err,
  output logic              cfg_err
);
  import dpf_pkg::*;

  localparam int BPW = WORD_W / 8;
  localparam int CAP = DEPTH * BPW;
  localparam int CW  = $clog2(CAP+1);
  localparam int NW  = $clog2(BPW+1);

  logic [NW-1:0]     src_n, dst_n, rd_n;
  logic [CW-1:0]     thr_n;
  logic [CW-1:0]     fill_bytes;
  logic              flush_active;
  logic              wr_go, rd_go, st_avail;
  logic [WORD_W-1:0] window;

  assign src_n = NW'(unit_bytes(src_size));
  assign dst_n = NW'(unit_bytes(dst_size));
  assign thr_n = CW'(((32'(thr_sel) + 32'd1) * CAP) / 4);

  dpf_drain_ctl #(.CAP(CAP), .BPW(BPW)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .fifo_en      (fifo_en),
    .push_en      (push_en),
    .src_n        (src_n),
    .pop_req      (pop_req),
    .dst_n        (dst_n),
    .thr_n        (thr_n),
    .flush        (flush),
    .wr_go        (wr_go),
    .rd_go        (rd_go),
    .rd_n         (rd_n),
    .level        (fill_bytes),
    .flush_active (flush_active),
    .avail        (st_avail),
    .fifo_err     (fifo_err)
  );

  dpf_byte_store #(.CAP(CAP), .BPW(BPW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_go     (wr_go),
    .wr_n      (src_n),
    .wr_data   (push_data),
    .rd_go     (rd_go),
    .rd_n      (rd_n),
    .rd_window (window)
  );

  dpf_cfg_check #(.CAP(CAP), .BPW(BPW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .fifo_en   (fifo_en),
    .thr_n     (thr_n),
    .dst_n     (dst_n),
    .dst_burst (dst_burst),
    .cfg_err   (cfg_err)
  );

  // output lanes: stored bytes up to the unit length, zero above
  logic [WORD_W-1:0] staged;
  always_comb begin
    for (int k = 0; k < BPW; k++)
      staged[8*k +: 8] = (NW'(k) < rd_n) ? window[8*k +: 8] : 8'h00;
  end

  assign pop_avail = fifo_en ? st_avail : push_en;
  assign pop_data  = fifo_en ? staged   : push_data;

endmodule

// File: rtl/dma_pack_fifo_chk.sv
module dma_pack_fifo_chk #(
  parameter int CAP = 16,
  parameter int CW  = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic [1:0]    thr_sel,
  input logic [1:0]    src_size,
  input logic [1:0]    dst_size,
  input logic          push_en,
  input logic          pop_req,
  input logic          pop_avail,
  input logic          fifo_err,
  input logic          cfg_err,
  input logic [CW-1:0] fill_bytes,
  input logic          flush_active
);
  import dpf_pkg::*;

  logic [CW:0] thr_b, src_b, dst_b;
  assign thr_b = (CW+1)'((32'(thr_sel) + 32'd1) * CAP / 4);
  assign src_b = (CW+1)'(unit_bytes(src_size));
  assign dst_b = (CW+1)'(unit_bytes(dst_size));

  // R3: drain offered only at threshold outside flush
  a_r3_drain_gate: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && pop_avail && !flush_active) |->
      ({1'b0, fill_bytes} >= thr_b && {1'b0, fill_bytes} >= dst_b));

  // R6: level never beyond capacity
  a_r6_level_bound: assert property (@(posedge clk) disable iff (rst)
    {1'b0, fill_bytes} <= (CW+1)'(CAP));

  // R6: push that does not fit raises the flag
  a_r6_overflow_flag: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && push_en && ({1'b0, fill_bytes} + src_b > (CW+1)'(CAP))) |=> fifo_err);

  // R7: pop with nothing offered raises the flag
  a_r7_underflow_flag: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && pop_req && !pop_avail) |=> fifo_err);

  // R7: flag is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    fifo_err |=> fifo_err);

  // R8: bypass leaves the store untouched
  a_r8_bypass_hold: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> $stable(fill_bytes));

  // R9: no configuration flag while disabled
  a_r9_cfg_quiet: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> !cfg_err);

endmodule

bind dma_pack_fifo dma_pack_fifo_chk #(.CAP(CAP), .CW(CW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fifo_en      (fifo_en),
  .thr_sel      (thr_sel),
  .src_size     (src_size),
  .dst_size     (dst_size),
  .push_en      (push_en),
  .pop_req      (pop_req),
  .pop_avail    (pop_avail),
  .fifo_err     (fifo_err),
  .cfg_err      (cfg_err),
  .fill_bytes   (fill_bytes),
  .flush_active (flush_active)
);

// File: tb/dma_pack_fifo_tb.sv
module dma_pack_fifo_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        fifo_en;
  logic [1:0]  thr_sel, src_size, dst_size, dst_burst;
  logic        push_en, pop_req, flush;
  logic [31:0] push_data;
  logic        pop_avail, fifo_err, cfg_err;
  logic [31:0] pop_data;

  always #4 clk = ~clk;

  dma_pack_fifo u_dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .thr_sel(thr_sel),
    .src_size(src_size), .dst_size(dst_size), .dst_burst(dst_burst),
    .push_en(push_en), .push_data(push_data), .pop_req(pop_req),
    .pop_avail(pop_avail), .pop_data(pop_data), .flush(flush),
    .fifo_err(fifo_err), .cfg_err(cfg_err)
  );

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  // reference model
  byte unsigned q[$];
  bit m_flush, m_err, m_cfg;

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction
  function automatic int beats(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 16;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_avail(input bit pe);
    int db, thr;
    if (!fifo_en) return pe;
    db  = nbytes(dst_size);
    thr = (thr_sel + 1) * 4;
    if (q.size() == 0) return 0;
    if (m_flush) return 1;
    return (q.size() >= db) && (q.size() >= thr);
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] pd);
    logic [31:0] d = '0;
    int n;
    if (!fifo_en) return pd;
    n = nbytes(dst_size);
    if (q.size() < n) n = q.size();
    for (int k = 0; k < n; k++) d[8*k +: 8] = q[k];
    return d;
  endfunction

  // one cycle: drive, compare before edge, advance model at edge
  task automatic step(input bit pe, input logic [31:0] pd, input bit pr, input bit fl);
    bit av;
    logic [31:0] ed;
    int sz0, sb, n;
    push_en = pe; push_data = pd; pop_req = pr; flush = fl;
    #2;
    av = exp_avail(pe);
    ed = exp_data(pd);
    check(pop_avail == av, cur_tag, 32'(pop_avail), 32'(av));
    if (av) check(pop_data == ed, cur_tag, pop_data, ed);
    check(fifo_err == m_err, cur_tag, 32'(fifo_err), 32'(m_err));
    check(cfg_err == m_cfg, cur_tag, 32'(cfg_err), 32'(m_cfg));
    @(posedge clk);
    sz0 = q.size();
    sb  = nbytes(src_size);
    if (fifo_en) begin
      if (pr) begin
        if (av) begin
          n = nbytes(dst_size);
          if (sz0 < n) n = sz0;
          for (int k = 0; k < n; k++) void'(q.pop_front());
        end else m_err = 1;
      end
      if (pe) begin
        if (sz0 + sb <= 16) begin
          for (int k = 0; k < sb; k++) q.push_back(pd[8*k +: 8]);
        end else m_err = 1;
      end
      if (fl) m_flush = 1;
      else if (m_flush && q.size() == 0) m_flush = 0;
    end
    m_cfg = fifo_en && ((((thr_sel + 1) * 4) % (beats(dst_burst) * nbytes(dst_size))) != 0);
    @(negedge clk);
    push_en = 0; pop_req = 0; flush = 0;
  endtask

  task automatic do_reset(input bit en, input logic [1:0] th, input logic [1:0] ss,
                          input logic [1:0] ds, input logic [1:0] bu);
    rst = 1; fifo_en = en; thr_sel = th; src_size = ss; dst_size = ds; dst_burst = bu;
    push_en = 0; pop_req = 0; flush = 0; push_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    q.delete(); m_flush = 0; m_err = 0; m_cfg = 0;
    #1;
    check(pop_avail == 1'b0 || !en, "R1", 32'(pop_avail), 32'd0);
    check(fifo_err == 1'b0, "R1", 32'(fifo_err), 32'd0);
    check(cfg_err == 1'b0, "R1", 32'(cfg_err), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; fifo_en = 0; thr_sel = 0; src_size = 0; dst_size = 0; dst_burst = 0;
    push_en = 0; pop_req = 0; flush = 0; push_data = '0;
    @(negedge clk);

    // R1 and R2: byte source into word destination, quarter threshold
    do_reset(1, 2'd0, 2'd0, 2'd2, 2'd0);
    cur_tag = "R2";
    step(1, 32'h11, 0, 0); step(1, 32'h22, 0, 0); step(1, 32'h33, 0, 0);
    step(1, 32'h44, 0, 0);
    #2; check(pop_avail && pop_data == 32'h44332211, "R2", pop_data, 32'h44332211);
    @(negedge clk);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);

    // R4: word source into byte destination, half threshold
    do_reset(1, 2'd1, 2'd2, 2'd0, 2'd0);
    cur_tag = "R4";
    step(1, 32'hA4A3A2A1, 0, 0);
    step(1, 32'hB4B3B2B1, 0, 0);
    #2; check(pop_data == 32'h000000A1, "R4", pop_data, 32'h000000A1);
    @(negedge clk);
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0);
    step(0, 0, 0, 0);

    // R3: halfwords into words, full threshold, four-beat burst
    do_reset(1, 2'd3, 2'd1, 2'd2, 2'd1);
    cur_tag = "R3";
    for (int i = 0; i < 7; i++) step(1, 32'(16'h1000 + i), 0, 0);
    #2; check(pop_avail == 1'b0, "R3", 32'(pop_avail), 32'd0);
    @(negedge clk);
    step(1, 32'h1007, 0, 0);
    #2; check(pop_avail == 1'b1, "R3", 32'(pop_avail), 32'd1);
    @(negedge clk);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0);

    // R5: flush releases a short tail, zero padded
    do_reset(1, 2'd3, 2'd0, 2'd2, 2'd0);
    cur_tag = "R5";
    step(1, 32'h5A, 0, 0); step(1, 32'h6B, 0, 0); step(1, 32'h7C, 0, 0);
    step(0, 0, 0, 1);
    #2; check(pop_avail && pop_data == 32'h007C6B5A, "R5", pop_data, 32'h007C6B5A);
    @(negedge clk);
    step(0, 0, 1, 0);
    step(1, 32'h01, 0, 0);
    #2; check(pop_avail == 1'b0, "R5", 32'(pop_avail), 32'd0);
    @(negedge clk);

    // R6: overflow drops the push, keeps data
    do_reset(1, 2'd3, 2'd2, 2'd2, 2'd0);
    cur_tag = "R6";
    for (int i = 0; i < 4; i++) step(1, 32'hC0DE0000 + 32'(i), 0, 0);
    step(1, 32'hDEADBEEF, 0, 0);
    #2; check(fifo_err == 1'b1, "R6", 32'(fifo_err), 32'd1);
    @(negedge clk);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0);

    // R7: underflow on empty store
    do_reset(1, 2'd0, 2'd0, 2'd0, 2'd0);
    cur_tag = "R7";
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    #2; check(fifo_err == 1'b1, "R7", 32'(fifo_err), 32'd1);
    @(negedge clk);

    // R8: bypass
    do_reset(0, 2'd3, 2'd2, 2'd0, 2'd3);
    cur_tag = "R8";
    for (int i = 0; i < 24; i++) step($urandom_range(0, 1), $urandom, $urandom_range(0, 1), 0);
    #2; check(fifo_err == 1'b0 && cfg_err == 1'b0, "R8", 32'(fifo_err), 32'd0);
    @(negedge clk);

    // R9: threshold versus burst
    do_reset(1, 2'd0, 2'd2, 2'd2, 2'd1);
    cur_tag = "R9";
    step(0, 0, 0, 0);
    #2; check(cfg_err == 1'b1, "R9", 32'(cfg_err), 32'd1);
    @(negedge clk);
    thr_sel = 2'd3;
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    #2; check(cfg_err == 1'b0, "R9", 32'(cfg_err), 32'd0);
    @(negedge clk);

    // mixed random traffic over many configurations
    for (int r = 0; r < 40; r++) begin
      do_reset(1, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 2)),
               2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)));
      cur_tag = "R3";
      for (int i = 0; i < 200; i++)
        step($urandom_range(0, 2) != 0, $urandom, $urandom_range(0, 2) == 0,
             $urandom_range(0, 40) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule